// File: doc/BRIEF.md
# Keyed nonvolatile word write controller

This block programs one 16-bit word into a small internal word store that stands in for a data EEPROM. A processor reaches it through a simple register port with a write strobe, a read strobe, a 3-bit register select, a 16-bit offset and 16-bit data. Software first sets an 8-bit page register. It then does a table write, which captures the 16-bit offset as the low part of the target address and the data word into a holding latch. Last, it sets a start bit in the control register.

Programming is protected. The start bit is honoured only if the key register has just received 0x0055 and then 0x00AA on two back-to-back bus accesses, and the control write follows straight after with no other access in between. A start without that unlock raises a sticky error flag and does nothing else. A valid start holds the block busy for `BUSY_CYC` cycles. The latched word is then committed to the store and the start bit clears itself. Every start uses up the unlock.

The store is indexed by word: index = address bits [IDX_W:1], so address bit 0 is ignored. With the default `IDX_W` the page bits lie above the index and do not select a word, but they are still kept and read back. Software is assumed to have erased the target word. Erase, row and block operations are not part of this block.

Top module: `nvw_ctrl`

## Requirements
- R1: After reset, `busy_o` and `err_o` are low, and reads of page (select 0), latch (select 1), address (select 2), control (select 3) and every store word (select 5) return 0.
- R2: A write to select 0 stores `bus_wdata[7:0]` as the page, and a read of select 0 returns it zero-extended. A write to select 1 (table write) stores `bus_wdata` in the holding latch and `bus_off` in the address register. Reads of select 1 and select 2 return the latch and the address.
- R3: Key writes (select 4) of 0x0055 and then 0x00AA on two consecutive accesses arm the unlock. A control write (select 3) on the next access with bit 15 (start), bit 14 (write enable) and bits [3:0] = 0100 (one data word) then sets `busy_o` from the following cycle for exactly `BUSY_CYC` cycles.
- R4: When the busy period ends, the latched word is written to store index `addr[IDX_W:1]`, so address bit 0 has no effect. A read of select 5 returns the word at index `bus_off[IDX_W:1]`.
- R5: Any other access between the two keys, or between 0x00AA and the control write, cancels the unlock. This covers a read or a write, to any select, including a wrong key value. A later control write with bit 15 set then starts nothing and sets `err_o`.
- R6: `err_o` (control bit 13) is sticky. An idle control write with bit 13 = 0 clears it. A rejected start in the same write sets it instead.
- R7: A control write with bit 15 set after a valid unlock, but with bit 14 clear or with bits [3:0] other than 0100, starts nothing and leaves `err_o` unchanged. It still uses up the unlock.
- R8: While `busy_o` is high, writes to the page, the table write port and the control register are ignored, including an error clear.
- R9: Each start uses up the unlock. A second start without a new key sequence is refused and sets `err_o`.
- R10: A control read returns bit 15 = busy, bit 14 = write enable, bit 13 = error and bits [3:0] = operation code, with all other bits 0. Reads of select 4, 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (counts as an access) |
| bus_sel | input | 3 | Register select: 0 page, 1 table write/latch, 2 address, 3 control, 4 key, 5 store word |
| bus_off | input | 16 | Table write offset; store read offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register |
| busy_o | output | 1 | Programming cycle in progress |
| err_o | output | 1 | Sticky rejected-start flag |

## Verification
On every cycle, the assertions check four things. Busy rises only right after a control write made while the unlock was armed. The unlock arms only right after a 0x00AA key write. The latch and the address stay frozen through the busy period, and that period lasts exactly `BUSY_CYC` cycles. They also check that a start without the unlock always raises the error flag. Other behaviour can only be shown by the bench's scenarios, which compare against a behavioural model: which store word receives the data, that address bit 0 is ignored, that reads in the middle of the key sequence cancel it, that a bad mode or missing write enable is refused quietly, and that the error flag follows its set-over-clear priority.

// File: rtl/nvw_pkg.sv
package nvw_pkg;
  typedef enum logic [2:0] {
    SEL_PAGE = 3'd0,
    SEL_TBLW = 3'd1,
    SEL_ADDR = 3'd2,
    SEL_CTRL = 3'd3,
    SEL_KEY  = 3'd4,
    SEL_ARR  = 3'd5
  } nvw_sel_e;

  typedef enum logic [1:0] {
    KS_IDLE  = 2'd0,
    KS_FIRST = 2'd1,
    KS_ARMED = 2'd2
  } nvw_key_e;

  localparam logic [15:0] KEY_FIRST  = 16'h0055;
  localparam logic [15:0] KEY_SECOND = 16'h00AA;
  localparam logic [3:0]  OP_WORD    = 4'b0100;

  localparam int CTL_START = 15;
  localparam int CTL_WEN   = 14;
  localparam int CTL_ERR   = 13;
endpackage

// File: rtl/nvw_unlock.sv
module nvw_unlock
  import nvw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_i,
  input  logic        key_wr_i,
  input  logic [15:0] key_i,
  output logic        armed_o
);
  nvw_key_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (key_wr_i) begin
      if (key_i == KEY_FIRST)                        st_d = KS_FIRST;
      else if (key_i == KEY_SECOND && st_q == KS_FIRST) st_d = KS_ARMED;
      else                                           st_d = KS_IDLE;
    end else if (acc_i) begin
      st_d = KS_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KS_IDLE;
    else        st_q <= st_d;
  end

  assign armed_o = (st_q == KS_ARMED);
endmodule

// File: rtl/nvw_busy_timer.sv
module nvw_busy_timer #(
  parameter int CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = (CYC > 1) ? $clog2(CYC) : 1;

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign done_o = busy_q && (cnt_q == '0);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end else if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(CYC - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/nvw_word_array.sv
module nvw_word_array #(
  parameter int IDX_W = 5,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [DW-1:0]    rdata_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0] word_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic hit;
    assign hit = we_i && (widx_i == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q[g] <= '0;
      else if (hit) word_q[g] <= wdata_i;
    end
  end

  assign rdata_o = word_q[ridx_i];
endmodule

// File: rtl/nvw_ctrl.sv
module nvw_ctrl
  import nvw_pkg::*;
#(
  parameter int IDX_W    = 5,
  parameter int BUSY_CYC = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic        bus_re,
  input  logic [2:0]  bus_sel,
  input  logic [15:0] bus_off,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        busy_o,
  output logic        err_o
);
  logic rst_meta, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sn   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sn   <= rst_meta;
    end
  end

  logic [7:0]  page_q, page_d;
  logic [15:0] addr_q, addr_d;
  logic [15:0] latch_q, latch_d;
  logic        wen_q, wen_d;
  logic [3:0]  op_q, op_d;
  logic        err_q, err_d;

  logic        busy, done, armed, go;
  logic        acc, wr_idle, page_wr, tblw_wr, ctrl_wr, key_wr;
  logic [15:0] arr_rdata;

  assign acc     = bus_we | bus_re;
  assign wr_idle = bus_we && !busy;
  assign page_wr = wr_idle && (bus_sel == SEL_PAGE);
  assign tblw_wr = wr_idle && (bus_sel == SEL_TBLW);
  assign ctrl_wr = wr_idle && (bus_sel == SEL_CTRL);
  assign key_wr  = bus_we && (bus_sel == SEL_KEY);

  assign go = ctrl_wr && bus_wdata[CTL_START] && armed &&
              bus_wdata[CTL_WEN] && (bus_wdata[3:0] == OP_WORD);

  nvw_unlock u_unlock (
    .clk      (clk),
    .rst_n    (rst_sn),
    .acc_i    (acc),
    .key_wr_i (key_wr),
    .key_i    (bus_wdata),
    .armed_o  (armed)
  );

  nvw_busy_timer #(.CYC(BUSY_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_sn),
    .start_i (go),
    .busy_o  (busy),
    .done_o  (done)
  );

  nvw_word_array #(.IDX_W(IDX_W), .DW(16)) u_array (
    .clk     (clk),
    .rst_n   (rst_sn),
    .we_i    (done),
    .widx_i  (addr_q[IDX_W:1]),
    .wdata_i (latch_q),
    .ridx_i  (bus_off[IDX_W:1]),
    .rdata_o (arr_rdata)
  );

  always_comb begin
    page_d  = page_q;
    addr_d  = addr_q;
    latch_d = latch_q;
    wen_d   = wen_q;
    op_d    = op_q;
    err_d   = err_q;
    if (page_wr) page_d = bus_wdata[7:0];
    if (tblw_wr) begin
      addr_d  = bus_off;
      latch_d = bus_wdata;
    end
    if (ctrl_wr) begin
      wen_d = bus_wdata[CTL_WEN];
      op_d  = bus_wdata[3:0];
      if (bus_wdata[CTL_START] && !armed) err_d = 1'b1;
      else if (!bus_wdata[CTL_ERR])       err_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      page_q  <= '0;
      addr_q  <= '0;
      latch_q <= '0;
      wen_q   <= 1'b0;
      op_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      page_q  <= page_d;
      addr_q  <= addr_d;
      latch_q <= latch_d;
      wen_q   <= wen_d;
      op_q    <= op_d;
      err_q   <= err_d;
    end
  end

  always_comb begin
    case (bus_sel)
      SEL_PAGE: bus_rdata = {8'h00, page_q};
      SEL_TBLW: bus_rdata = latch_q;
      SEL_ADDR: bus_rdata = addr_q;
      SEL_CTRL: bus_rdata = {busy, wen_q, err_q, 9'b0, op_q};
      SEL_ARR:  bus_rdata = arr_rdata;
      default:  bus_rdata = 16'h0000;
    endcase
  end

  assign busy_o = busy;
  assign err_o  = err_q;
endmodule

// File: rtl/nvw_chk.sv
module nvw_chk #(
  parameter int BUSY_CYC = 8
) (
  input logic        clk,
  input logic        rst_sn,
  input logic        bus_we,
  input logic [2:0]  bus_sel,
  input logic [15:0] bus_wdata,
  input logic        busy_o,
  input logic        err_o,
  input logic        armed,
  input logic [15:0] latch_q,
  input logic [15:0] addr_q
);
  int unsigned run_q;
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     run_q <= 0;
    else if (busy_o) run_q <= run_q + 1;
    else             run_q <= 0;
  end

  // R3
  start_after_unlock_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(busy_o) |-> ($past(armed) && $past(bus_we) && $past(bus_sel) == 3'd3));

  // R3
  arm_after_key_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(armed) |-> ($past(bus_we) && $past(bus_sel) == 3'd4 && $past(bus_wdata) == 16'h00AA));

  // R3
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(busy_o) |-> (run_q == BUSY_CYC));

  // R3
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    run_q <= BUSY_CYC);

  // R5
  bad_start_err_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_we && bus_sel == 3'd3 && !busy_o && bus_wdata[15] && !armed) |=> err_o);

  // R8
  frozen_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy_o && $past(busy_o)) |-> ($stable(latch_q) && $stable(addr_q)));
endmodule

bind nvw_ctrl nvw_chk #(.BUSY_CYC(BUSY_CYC)) u_chk (
  .clk       (clk),
  .rst_sn    (rst_sn),
  .bus_we    (bus_we),
  .bus_sel   (bus_sel),
  .bus_wdata (bus_wdata),
  .busy_o    (busy_o),
  .err_o     (err_o),
  .armed     (armed),
  .latch_q   (latch_q),
  .addr_q    (addr_q)
);

// File: tb/sim_nvw_ctrl.sv
`timescale 1ns/1ps
module sim_nvw_ctrl;
  localparam int IDX_W = 5;
  localparam int BUSY  = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [2:0]  bus_sel = 3'd0;
  logic [15:0] bus_off = 16'h0, bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        busy_o, err_o;

  always #5 clk = ~clk;

  nvw_ctrl #(.IDX_W(IDX_W), .BUSY_CYC(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_sel(bus_sel), .bus_off(bus_off), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .busy_o(busy_o), .err_o(err_o)
  );

  int errors = 0;
  int checks = 0;
  bit live = 0;
  bit finished = 0;

  // behavioural reference state
  int m_key = 0;
  int m_left = 0;
  bit m_busy = 0, m_err = 0;
  int m_mem [32];

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic model();
    bit acc = bus_we | bus_re;
    bit old_busy = m_busy;
    int old_key = m_key;
    if (m_busy) begin
      m_left--;
      if (m_left == 0) m_busy = 0;
    end
    if (bus_we && !old_busy && bus_sel == 3'd3) begin
      if (bus_wdata[15] && old_key != 2) m_err = 1;
      else if (!bus_wdata[13]) m_err = 0;
      if (bus_wdata[15] && old_key == 2 && bus_wdata[14] && bus_wdata[3:0] == 4'd4) begin
        m_busy = 1;
        m_left = BUSY;
      end
    end
    if (bus_we && bus_sel == 3'd4) begin
      if (bus_wdata == 16'h0055) m_key = 1;
      else if (bus_wdata == 16'h00AA && old_key == 1) m_key = 2;
      else m_key = 0;
    end else if (acc) m_key = 0;
  endtask

  task automatic step();
    @(posedge clk);
    if (live) model();
    @(negedge clk);
    if (live) begin
      check("R3 busy vs model", busy_o, m_busy);
      check("R6 err vs model", err_o, m_err);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(logic [2:0] s, logic [15:0] off, logic [15:0] d);
    bus_we = 1'b1; bus_sel = s; bus_off = off; bus_wdata = d;
    step();
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] s, logic [15:0] off, logic [15:0] exp, string tag);
    bus_re = 1'b1; bus_sel = s; bus_off = off;
    #1;
    check(tag, bus_rdata, exp);
    step();
    bus_re = 1'b0;
  endtask

  task automatic keys();
    wr(3'd4, 16'h0, 16'h0055);
    wr(3'd4, 16'h0, 16'h00AA);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    live = 1;
    // R1 reset state
    check("R1 busy", busy_o, 0);
    check("R1 err", err_o, 0);
    rd(3'd0, 16'h0, 16'h0000, "R1 page");
    rd(3'd1, 16'h0, 16'h0000, "R1 latch");
    rd(3'd2, 16'h0, 16'h0000, "R1 addr");
    rd(3'd3, 16'h0, 16'h0000, "R1 ctrl");
    rd(3'd5, 16'h6, 16'h0000, "R1 store");
    // R2 page and table write
    wr(3'd0, 16'h0, 16'hFF12);
    wr(3'd1, 16'h0007, 16'hBEEF);
    rd(3'd0, 16'h0, 16'h0012, "R2 page");
    rd(3'd1, 16'h0, 16'hBEEF, "R2 latch");
    rd(3'd2, 16'h0, 16'h0007, "R2 addr");
    // R3 keyed start
    keys();
    wr(3'd3, 16'h0, 16'hC004);
    check("R3 busy after start", busy_o, 1);
    // R8 writes during busy ignored
    wr(3'd1, 16'h0010, 16'h1234);
    wr(3'd0, 16'h0, 16'h0077);
    wr(3'd3, 16'h0, 16'h0000);
    rd(3'd1, 16'h0, 16'hBEEF, "R8 latch frozen");
    rd(3'd0, 16'h0, 16'h0012, "R8 page frozen");
    rd(3'd3, 16'h0, 16'hC004, "R10 ctrl while busy");
    idle(4);
    check("R3 busy ended", busy_o, 0);
    // R4 commit to index 3, bit 0 ignored
    rd(3'd5, 16'h0006, 16'hBEEF, "R4 store even off");
    rd(3'd5, 16'h0007, 16'hBEEF, "R4 store odd off");
    rd(3'd5, 16'h0008, 16'h0000, "R4 neighbour untouched");
    rd(3'd3, 16'h0, 16'h4004, "R10 ctrl after done");
    rd(3'd4, 16'h0, 16'h0000, "R10 key reads 0");
    rd(3'd7, 16'h0, 16'h0000, "R10 unused select");
    // R9 second start without keys
    wr(3'd3, 16'h0, 16'hC004);
    check("R9 no busy", busy_o, 0);
    check("R9 err set", err_o, 1);
    rd(3'd3, 16'h0, 16'h6004, "R10 ctrl with err");
    // R6 error clear
    wr(3'd3, 16'h0, 16'h2004);
    check("R6 err held on bit13=1", err_o, 1);
    wr(3'd3, 16'h0, 16'h4004);
    check("R6 err cleared", err_o, 0);
    // R5 read between keys
    wr(3'd4, 16'h0, 16'h0055);
    rd(3'd0, 16'h0, 16'h0012, "R5 page read");
    wr(3'd4, 16'h0, 16'h00AA);
    wr(3'd3, 16'h0, 16'hC004);
    check("R5 no start gap1", busy_o, 0);
    check("R5 err gap1", err_o, 1);
    wr(3'd3, 16'h0, 16'h4004);
    // R5 read between second key and start
    keys();
    rd(3'd1, 16'h0, 16'hBEEF, "R5 latch read");
    wr(3'd3, 16'h0, 16'hC004);
    check("R5 no start gap2", busy_o, 0);
    check("R5 err gap2", err_o, 1);
    // R5 wrong order; R6 rejected start wins over clear
    wr(3'd4, 16'h0, 16'h00AA);
    wr(3'd4, 16'h0, 16'h0055);
    wr(3'd3, 16'h0, 16'h8004);
    check("R6 set beats clear", err_o, 1);
    wr(3'd3, 16'h0, 16'h0004);
    check("R6 cleared", err_o, 0);
    // R7 missing write enable / wrong op consume unlock quietly
    keys();
    wr(3'd3, 16'h0, 16'h8004);
    check("R7 no wen no busy", busy_o, 0);
    check("R7 no wen no err", err_o, 0);
    wr(3'd3, 16'h0, 16'hC004);
    check("R7 unlock consumed", err_o, 1);
    wr(3'd3, 16'h0, 16'h4004);
    keys();
    wr(3'd3, 16'h0, 16'hC005);
    check("R7 bad op no busy", busy_o, 0);
    check("R7 bad op no err", err_o, 0);
    // R3 repeated first key restarts sequence; odd address
    wr(3'd1, 16'h0009, 16'hA5C3);
    wr(3'd4, 16'h0, 16'h0055);
    keys();
    wr(3'd3, 16'h0, 16'hC004);
    check("R3 restart key start", busy_o, 1);
    idle(BUSY);
    rd(3'd5, 16'h0008, 16'hA5C3, "R4 odd address index 4");
    rd(3'd5, 16'h0006, 16'hBEEF, "R4 earlier word kept");
    idle(2);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule